// File: doc/BRIEF.md
# Cartridge bank-switch controller

This block sits between the CPU bus, the picture-processor bus and the ROM chips of an 8-bit console cartridge. A single write-only latch holds two bank numbers. One picks the 32 KB program ROM bank seen in the upper half of CPU space. The other picks the 8 KB character ROM bank seen at video addresses $0000-$1FFF. The block drives the upper ROM address lines, the ROM enables and the nametable select line. The mirroring direction comes from a static configuration input.

A CPU write into the register window loads the latch. When the write lands in ROM space, the ROM drives the data bus during the write as well. The block models this bus conflict by latching the bitwise AND of the CPU byte and the ROM byte. The `WINDOW_SEL` parameter moves the register window. The `MODE` parameter picks the standard layout, a reduced layout with a single program-bank bit, or a wide layout in which all eight latch bits count.

Top module: `cart_bank_ctrl`

## Requirements
- R1: While `rst_n` is low the latch is cleared, so program bank 0 and character bank 0 are mapped until the first register write.
- R2: Program ROM address = {program bank, `cpu_addr[14:0]`}. Character ROM address = {character bank, `ppu_addr[12:0]`}. A register write is visible on both from the clock edge that captures it.
- R3: In the standard mode, latch bits [5:4] form the program bank and bits [1:0] form the character bank. Bits 7, 6, 3 and 2 of a written byte have no effect.
- R4: A register write with `cpu_addr[15]`=1 stores `cpu_wdata & rom_rdata`. A write with `cpu_addr[15]`=0 stores `cpu_wdata` unchanged.
- R5: The latch changes only on a clock edge with `cpu_wr`=1 and an address inside the window. CPU reads, and writes outside the window, leave both banks unchanged.
- R6: With `WINDOW_SEL`=0 the window is $8000-$FFFF. With `WINDOW_SEL`=1 it is $6000-$7FFF, and writes to $8000-$FFFF are ignored.
- R7: In the reduced mode only latch bit 4 selects the program bank (1 bit, 16-bit program address), and bit 5 is ignored.
- R8: In the wide mode, bits [7:4] form a 4-bit program bank (19-bit address, 512 KB) and bits [3:0] form a 4-bit character bank (17-bit address, 128 KB).
- R9: `prg_rom_ce` = `cpu_rd` AND `cpu_addr[15]`. `chr_rom_ce` = `ppu_rd` AND `ppu_addr` < $2000.
- R10: `nt_sel` follows `ppu_addr[10]` when `mirror_vert`=1 (vertical mirroring) and follows `ppu_addr[11]` when `mirror_vert`=0 (horizontal mirroring).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mirror_vert | input | 1 | Static mirroring configuration: 1 = vertical, 0 = horizontal |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the clock edge |
| cpu_rd | input | 1 | CPU read cycle |
| rom_rdata | input | 8 | Byte the program ROM drives at `cpu_addr` |
| ppu_addr | input | 14 | Video address |
| ppu_rd | input | 1 | Video read cycle |
| prg_rom_addr | output | 17 (std), 16 (reduced), 19 (wide) | Program ROM address |
| prg_rom_ce | output | 1 | Program ROM enable |
| chr_rom_addr | output | 15 (std/reduced), 17 (wide) | Character ROM address |
| chr_rom_ce | output | 1 | Character ROM enable |
| nt_sel | output | 1 | Nametable RAM select line |

## Verification
The only state is the bank latch. A wrong value in it shows on the upper bits of both ROM addresses in the same cycle, with no further latency. So every write is followed by a probe read that compares those upper bits against values worked out from the written byte and the ROM byte. The vectors mix ignored bits, conflicts that clear bits, and writes that must not land. Mode and window variants run side by side on the same stimulus, so a write that one variant must ignore is checked against a variant that must accept it.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

   typedef enum logic [1:0] {
      BANK_STD     = 2'd0,
      BANK_REDUCED = 2'd1,
      BANK_WIDE    = 2'd2
   } bank_mode_e;

   localparam int CPU_AW     = 16;
   localparam int PPU_AW     = 14;
   localparam int DATA_W     = 8;
   localparam int PRG_OFS_W  = 15;
   localparam int CHR_OFS_W  = 13;

   function automatic int prg_bw(bank_mode_e m);
      case (m)
         BANK_REDUCED: return 1;
         BANK_WIDE:    return 4;
         default:      return 2;
      endcase
   endfunction

   function automatic int chr_bw(bank_mode_e m);
      return (m == BANK_WIDE) ? 4 : 2;
   endfunction

   function automatic int prg_aw(bank_mode_e m);
      return PRG_OFS_W + prg_bw(m);
   endfunction

   function automatic int chr_aw(bank_mode_e m);
      return CHR_OFS_W + chr_bw(m);
   endfunction

endpackage

// File: rtl/cbk_window_decode.sv
module cbk_window_decode #(
   parameter int WINDOW_SEL = 0
) (
   input  logic [2:0] addr_top,
   input  logic       cpu_wr,
   output logic       wr_hit,
   output logic       conflict
);

   logic in_win;

   generate
      if (WINDOW_SEL == 1) begin : g_low_win
         assign in_win = (addr_top == 3'b011);
      end else begin : g_high_win
         logic mid_unused;
         assign mid_unused = ^addr_top[1:0];
         assign in_win = addr_top[2];
      end
   endgenerate

   assign wr_hit   = cpu_wr & in_win;
   assign conflict = addr_top[2];

endmodule

// File: rtl/cbk_bank_latch.sv
module cbk_bank_latch
   import cart_bank_pkg::*;
#(
   parameter bank_mode_e MODE = BANK_STD,
   localparam int PBW = prg_bw(MODE),
   localparam int CBW = chr_bw(MODE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic              conflict,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] rdata,
   output logic [PBW-1:0]    prg_bank,
   output logic [CBW-1:0]    chr_bank
);

   logic [DATA_W-1:0] eff;
   logic [PBW-1:0]    nxt_prg;
   logic [CBW-1:0]    nxt_chr;

   assign eff = conflict ? (wdata & rdata) : wdata;

   generate
      if (MODE == BANK_WIDE) begin : g_wide
         assign nxt_prg = eff[7:4];
         assign nxt_chr = eff[3:0];
      end else if (MODE == BANK_REDUCED) begin : g_reduced
         logic drop_unused;
         assign drop_unused = ^{eff[7:5], eff[3:2]};
         assign nxt_prg = eff[4];
         assign nxt_chr = eff[1:0];
      end else begin : g_std
         logic drop_unused;
         assign drop_unused = ^{eff[7:6], eff[3:2]};
         assign nxt_prg = eff[5:4];
         assign nxt_chr = eff[1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prg_bank <= '0;
         chr_bank <= '0;
      end else if (wr_hit) begin
         prg_bank <= nxt_prg;
         chr_bank <= nxt_chr;
      end
   end

   AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> ($stable(prg_bank) && $stable(chr_bank)));  // R5

   AST_ZERO_ROM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && conflict && rdata == '0) |=> (prg_bank == '0 && chr_bank == '0));  // R4

endmodule

// File: rtl/cbk_addr_map.sv
module cbk_addr_map
   import cart_bank_pkg::*;
#(
   parameter bank_mode_e MODE = BANK_STD,
   localparam int PBW = prg_bw(MODE),
   localparam int CBW = chr_bw(MODE),
   localparam int PAW = prg_aw(MODE),
   localparam int CAW = chr_aw(MODE)
) (
   input  logic [PBW-1:0]    prg_bank,
   input  logic [CBW-1:0]    chr_bank,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic [PPU_AW-1:0] ppu_addr,
   input  logic              ppu_rd,
   output logic [PAW-1:0]    prg_rom_addr,
   output logic              prg_rom_ce,
   output logic [CAW-1:0]    chr_rom_addr,
   output logic              chr_rom_ce
);

   assign prg_rom_addr = {prg_bank, cpu_addr[PRG_OFS_W-1:0]};
   assign chr_rom_addr = {chr_bank, ppu_addr[CHR_OFS_W-1:0]};
   assign prg_rom_ce   = cpu_rd & cpu_addr[CPU_AW-1];
   assign chr_rom_ce   = ppu_rd & ~ppu_addr[PPU_AW-1];

endmodule

// File: rtl/cbk_nt_mirror.sv
module cbk_nt_mirror (
   input  logic [1:0] ppu_a11_a10,
   input  logic       mirror_vert,
   output logic       nt_sel
);

   assign nt_sel = mirror_vert ? ppu_a11_a10[0] : ppu_a11_a10[1];

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
   import cart_bank_pkg::*;
#(
   parameter bank_mode_e MODE = BANK_STD,
   parameter int WINDOW_SEL = 0,
   localparam int PBW = prg_bw(MODE),
   localparam int CBW = chr_bw(MODE),
   localparam int PAW = prg_aw(MODE),
   localparam int CAW = chr_aw(MODE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mirror_vert,
   input  logic [CPU_AW-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] rom_rdata,
   input  logic [PPU_AW-1:0] ppu_addr,
   input  logic              ppu_rd,
   output logic [PAW-1:0]    prg_rom_addr,
   output logic              prg_rom_ce,
   output logic [CAW-1:0]    chr_rom_addr,
   output logic              chr_rom_ce,
   output logic              nt_sel
);

   generate
      if (WINDOW_SEL != 0 && WINDOW_SEL != 1) begin : g_bad_window
         $error("cart_bank_ctrl: WINDOW_SEL must be 0 or 1");
      end
      if (PBW + CBW > DATA_W) begin : g_bad_split
         $error("cart_bank_ctrl: bank fields exceed the latch width");
      end
   endgenerate

   logic           wr_hit;
   logic           conflict;
   logic [PBW-1:0] prg_bank;
   logic [CBW-1:0] chr_bank;

   cbk_window_decode #(.WINDOW_SEL(WINDOW_SEL)) u_decode (
      .addr_top (cpu_addr[CPU_AW-1 -: 3]),
      .cpu_wr   (cpu_wr),
      .wr_hit   (wr_hit),
      .conflict (conflict)
   );

   cbk_bank_latch #(.MODE(MODE)) u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (wr_hit),
      .conflict (conflict),
      .wdata    (cpu_wdata),
      .rdata    (rom_rdata),
      .prg_bank (prg_bank),
      .chr_bank (chr_bank)
   );

   cbk_addr_map #(.MODE(MODE)) u_map (
      .prg_bank     (prg_bank),
      .chr_bank     (chr_bank),
      .cpu_addr     (cpu_addr),
      .cpu_rd       (cpu_rd),
      .ppu_addr     (ppu_addr),
      .ppu_rd       (ppu_rd),
      .prg_rom_addr (prg_rom_addr),
      .prg_rom_ce   (prg_rom_ce),
      .chr_rom_addr (chr_rom_addr),
      .chr_rom_ce   (chr_rom_ce)
   );

   cbk_nt_mirror u_mirror (
      .ppu_a11_a10 (ppu_addr[11:10]),
      .mirror_vert (mirror_vert),
      .nt_sel      (nt_sel)
   );

   AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !cpu_wr) |=> ($stable(prg_bank) && $stable(chr_bank)));  // R5

   AST_PRG_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      prg_rom_addr[PRG_OFS_W-1:0] == cpu_addr[PRG_OFS_W-1:0]);  // R2

   AST_CHR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      chr_rom_addr[CHR_OFS_W-1:0] == ppu_addr[CHR_OFS_W-1:0]);  // R2

endmodule

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;
   import cart_bank_pkg::*;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mirror_vert = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_wr = 1'b0;
   logic        cpu_rd = 1'b0;
   logic [7:0]  rom_rdata = '0;
   logic [13:0] ppu_addr = '0;
   logic        ppu_rd = 1'b0;

   logic [16:0] s_prg; logic [14:0] s_chr; logic s_pce, s_cce, s_nt;
   logic [16:0] l_prg; logic [14:0] l_chr; logic l_pce, l_cce, l_nt;
   logic [15:0] r_prg; logic [14:0] r_chr; logic r_pce, r_cce, r_nt;
   logic [18:0] w_prg; logic [16:0] w_chr; logic w_pce, w_cce, w_nt;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cart_bank_ctrl #(.MODE(BANK_STD), .WINDOW_SEL(0)) u_dut (
      .clk(clk), .rst_n(rst_n), .mirror_vert(mirror_vert), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_rdata(rom_rdata),
      .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .prg_rom_addr(s_prg), .prg_rom_ce(s_pce),
      .chr_rom_addr(s_chr), .chr_rom_ce(s_cce), .nt_sel(s_nt));

   cart_bank_ctrl #(.MODE(BANK_STD), .WINDOW_SEL(1)) u_low (
      .clk(clk), .rst_n(rst_n), .mirror_vert(mirror_vert), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_rdata(rom_rdata),
      .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .prg_rom_addr(l_prg), .prg_rom_ce(l_pce),
      .chr_rom_addr(l_chr), .chr_rom_ce(l_cce), .nt_sel(l_nt));

   cart_bank_ctrl #(.MODE(BANK_REDUCED), .WINDOW_SEL(0)) u_red (
      .clk(clk), .rst_n(rst_n), .mirror_vert(mirror_vert), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_rdata(rom_rdata),
      .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .prg_rom_addr(r_prg), .prg_rom_ce(r_pce),
      .chr_rom_addr(r_chr), .chr_rom_ce(r_cce), .nt_sel(r_nt));

   cart_bank_ctrl #(.MODE(BANK_WIDE), .WINDOW_SEL(0)) u_wide (
      .clk(clk), .rst_n(rst_n), .mirror_vert(mirror_vert), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .rom_rdata(rom_rdata),
      .ppu_addr(ppu_addr), .ppu_rd(ppu_rd), .prg_rom_addr(w_prg), .prg_rom_ce(w_pce),
      .chr_rom_addr(w_chr), .chr_rom_ce(w_cce), .nt_sel(w_nt));

   typedef struct packed {
      logic [15:0] a;
      logic [7:0]  d;
      logic [7:0]  r;
      logic [3:0]  sp;
      logic [3:0]  sc;
      logic [3:0]  wp;
      logic [3:0]  wc;
      logic [3:0]  rp;
   } vec_t;

   localparam int NVEC = 7;
   localparam vec_t VEC [NVEC] = '{
      '{16'h8000, 8'h31, 8'hFF, 4'd3, 4'd1, 4'd3, 4'd1, 4'd1},
      '{16'hFFFF, 8'hFF, 8'h12, 4'd1, 4'd2, 4'd1, 4'd2, 4'd1},
      '{16'hC000, 8'hCC, 8'hFF, 4'd0, 4'd0, 4'hC, 4'hC, 4'd0},
      '{16'hA5A5, 8'h23, 8'h33, 4'd2, 4'd3, 4'd2, 4'd3, 4'd0},
      '{16'h8000, 8'h33, 8'h00, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0},
      '{16'h9000, 8'h10, 8'hFF, 4'd1, 4'd0, 4'd1, 4'd0, 4'd1},
      '{16'hE000, 8'hF0, 8'hFF, 4'd3, 4'd0, 4'hF, 4'd0, 4'd1}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic [7:0] r);
      @(negedge clk);
      cpu_rd = 1'b0; cpu_addr = a; cpu_wdata = d; rom_rdata = r; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic probe();
      cpu_wr = 1'b0; cpu_rd = 1'b1; cpu_addr = 16'h8ABC;
      ppu_rd = 1'b1; ppu_addr = 14'h0567;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      probe();
      chk("R1 reset std prg bank", 32'(s_prg[16:15]), 0);
      chk("R1 reset std chr bank", 32'(s_chr[14:13]), 0);
      chk("R1 reset wide prg bank", 32'(w_prg[18:15]), 0);
      rst_n = 1'b1;

      // table walk: R2 R3 R4 R7 R8, plus R6 (high-window writes ignored by u_low)
      for (int i = 0; i < NVEC; i++) begin
         do_write(VEC[i].a, VEC[i].d, VEC[i].r);
         probe();
         chk($sformatf("R2/R3/R4 vec%0d std prg", i), 32'(s_prg[16:15]), 32'(VEC[i].sp));
         chk($sformatf("R2/R3/R4 vec%0d std chr", i), 32'(s_chr[14:13]), 32'(VEC[i].sc));
         chk($sformatf("R8 vec%0d wide prg", i), 32'(w_prg[18:15]), 32'(VEC[i].wp));
         chk($sformatf("R8 vec%0d wide chr", i), 32'(w_chr[16:13]), 32'(VEC[i].wc));
         chk($sformatf("R7 vec%0d reduced prg", i), 32'(r_prg[15]), 32'(VEC[i].rp));
         chk($sformatf("R6 vec%0d low window ignores high write", i), 32'(l_prg[16:15]), 0);
      end

      // R5: read in window with data bus pattern does not load
      @(negedge clk);
      cpu_wdata = 8'h00; rom_rdata = 8'h00; cpu_addr = 16'h8000; cpu_rd = 1'b1;
      @(negedge clk);
      probe();
      chk("R5 read leaves std prg", 32'(s_prg[16:15]), 3);
      chk("R5 read leaves std chr", 32'(s_chr[14:13]), 0);

      // R5/R6: write below both windows
      do_write(16'h5000, 8'h11, 8'hFF);
      probe();
      chk("R5 write outside window std prg", 32'(s_prg[16:15]), 3);
      chk("R6 low window ignores $5000", 32'(l_chr[14:13]), 0);

      // R6 with R4: low window write, no conflict since A15=0
      do_write(16'h6000, 8'h21, 8'h00);
      probe();
      chk("R6 low window prg", 32'(l_prg[16:15]), 2);
      chk("R4 low window no conflict chr", 32'(l_chr[14:13]), 1);
      chk("R5 std ignores $6000", 32'(s_prg[16:15]), 3);
      do_write(16'h7FFF, 8'h13, 8'h00);
      probe();
      chk("R6 low window top prg", 32'(l_prg[16:15]), 1);
      chk("R6 low window top chr", 32'(l_chr[14:13]), 3);
      do_write(16'h8000, 8'h00, 8'hFF);
      probe();
      chk("R6 low window keeps after $8000", 32'(l_chr[14:13]), 3);
      chk("R2 std loads zero", 32'(s_prg[16:15]), 0);

      // R9 enables
      cpu_rd = 1'b1; cpu_addr = 16'h8000; #1;
      chk("R9 prg ce read high", 32'(s_pce), 1);
      cpu_addr = 16'h7FFF; #1;
      chk("R9 prg ce read low", 32'(s_pce), 0);
      cpu_rd = 1'b0; cpu_addr = 16'h8000; #1;
      chk("R9 prg ce idle", 32'(s_pce), 0);
      ppu_rd = 1'b1; ppu_addr = 14'h1FFF; #1;
      chk("R9 chr ce pattern", 32'(s_cce), 1);
      ppu_addr = 14'h2000; #1;
      chk("R9 chr ce nametable", 32'(s_cce), 0);
      ppu_rd = 1'b0; ppu_addr = 14'h0000; #1;
      chk("R9 chr ce idle", 32'(s_cce), 0);

      // R2 offsets
      cpu_addr = 16'hFFFF; ppu_addr = 14'h1ABC; #1;
      chk("R2 prg offset", 32'(s_prg[14:0]), 32'h7FFF);
      chk("R2 chr offset", 32'(s_chr[12:0]), 32'h1ABC);

      // R10 mirroring
      mirror_vert = 1'b1; ppu_addr = 14'h2400; #1;
      chk("R10 vertical $2400", 32'(s_nt), 1);
      ppu_addr = 14'h2800; #1;
      chk("R10 vertical $2800", 32'(s_nt), 0);
      mirror_vert = 1'b0; ppu_addr = 14'h2400; #1;
      chk("R10 horizontal $2400", 32'(s_nt), 0);
      ppu_addr = 14'h2800; #1;
      chk("R10 horizontal $2800", 32'(s_nt), 1);

      // R1 reset mid-run
      do_write(16'h8000, 8'h33, 8'hFF);
      probe();
      chk("R2 pre-reset prg", 32'(s_prg[16:15]), 3);
      rst_n = 1'b0; #1;
      chk("R1 async reset prg", 32'(s_prg[16:15]), 0);
      chk("R1 async reset chr", 32'(s_chr[14:13]), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

endmodule